// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block lets software reach the internal registers of an external Ethernet PHY over the two-wire management bus. Software fills a small set of registers through a simple word-wide register port: the PHY address, the 16-bit data to be written, a clock divider, and a control word. The control word holds the target PHY register number, a bit that selects write or read, and a start bit. Setting the start bit launches one clause-22 management frame.

While the frame runs, the block generates the management clock from the system clock through the software-set divider and shifts the frame out MSB first. On a read it lets go of the data line for the turnaround and data fields, samples the PHY's reply on each rising management-clock edge, and places the 16 bits in a receive-data register. The start bit reads back as one for as long as the frame runs and drops to zero by itself at the end, so software polls it for completion.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the management clock is low, the data line is released (output enable low), the divider reads 10, and the control and receive-data registers read 0.
- R2: Register map by `reg_addr`: 0 control, 1 divider, 2 PHY address (bits 4:0), 3 transmit data (bits 15:0), 4 receive data (bits 15:0, bits 31:16 read as zero). In the control word, bit 0 is start, bit 1 selects write (1) or read (0), and bits 7:3 hold the PHY register number; reading bit 0 returns 1 while a frame runs.
- R3: With divider value D latched at start, each management-clock half period lasts D+1 system clocks; the clock starts low, first rises D+1 clocks after the start write, and idles low between frames.
- R4: Every frame is 64 bit-times, one per management-clock period, with the bit changing on the falling edge: 32 ones, then 01, then opcode 01 (write) or 10 (read), 5-bit PHY address, 5-bit register number, then for a write turnaround 10 and the 16 transmit-data bits, all MSB first.
- R5: On a read the block drives the first 46 bit-times only and releases the line for the turnaround and the 16 data bit-times.
- R6: On a read the line is sampled on each rising management-clock edge of the 16 data bit-times, first bit into bit 15, and the result is placed in the receive-data register when the frame ends.
- R7: The start bit clears 128 x (D+1) system clocks after the start write, on the final falling management-clock edge.
- R8: Writes to the control register while a frame runs change nothing: the register number and write select read back unchanged and the running frame's timing is undisturbed.
- R9: Divider, PHY address and transmit data may be rewritten during a frame without affecting it; the frame uses the values in force when it started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The bench builds the block with its default parameters, an 8-bit divider field reset to 10, and then programs the divider to 0, 2 and 10 at run time. Divider 0 brings the fastest case within reach, where every system clock toggles the management clock and counter wrap and edge detection coincide each cycle; 10 covers the normal rate, and a divider rewritten mid-frame shows that the latched value governs. A behavioural PHY answers reads with chosen patterns whose first and last bits are set, so bit order and the sampling edge are both exposed.

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 10,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(46);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(48);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_LEN - 1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PHY = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TXD = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RXD = ADDR_W'(4);

  logic                 busy;
  logic [DIV_W-1:0]     div_q, div_l, cnt;
  logic [4:0]           phy_q, regn_q;
  logic                 wsel_q;
  logic [15:0]          txd_q, rxd_q, rsh;
  logic [FRAME_LEN-1:0] fsr;
  logic [IDX_W-1:0]     idx;

  wire half_end = busy && (cnt == div_l);
  wire rise     = half_end && !mdc;
  wire fall     = half_end && mdc;
  wire last     = fall && (idx == LAST_POS);
  wire ctl_wr   = reg_wr && (reg_addr == A_CTL) && !busy;
  wire launch   = ctl_wr && reg_wdata[0];
  wire new_wsel = reg_wdata[1];

  wire [FRAME_LEN-1:0] frame_new = {32'hFFFF_FFFF, 2'b01,
                                    new_wsel ? 2'b01 : 2'b10,
                                    phy_q, reg_wdata[7:3],
                                    new_wsel ? 2'b10 : 2'b11,
                                    new_wsel ? txd_q : 16'hFFFF};

  assign mdio_o  = fsr[FRAME_LEN-1];
  assign mdio_oe = busy && (wsel_q || idx < TA_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RESET);
      phy_q <= '0;
      txd_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_addr == A_PHY) phy_q <= reg_wdata[4:0];
      if (reg_addr == A_TXD) txd_q <= reg_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regn_q <= '0;
      wsel_q <= 1'b0;
    end else if (ctl_wr) begin
      regn_q <= reg_wdata[7:3];
      wsel_q <= new_wsel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      mdc   <= 1'b0;
      cnt   <= '0;
      div_l <= '0;
      idx   <= '0;
      fsr   <= '1;
      rsh   <= '0;
      rxd_q <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      mdc   <= 1'b0;
      cnt   <= '0;
      div_l <= div_q;
      idx   <= '0;
      fsr   <= frame_new;
    end else if (busy) begin
      cnt <= half_end ? '0 : cnt + 1'b1;
      if (rise) begin
        mdc <= 1'b1;
        if (!wsel_q && idx >= DATA_POS) rsh <= {rsh[14:0], mdio_i};
      end
      if (fall) begin
        mdc <= 1'b0;
        idx <= idx + 1'b1;
        fsr <= {fsr[FRAME_LEN-2:0], 1'b1};
      end
      if (last) begin
        busy <= 1'b0;
        if (!wsel_q) rxd_q <= rsh;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTL:   reg_rdata = {24'b0, regn_q, 1'b0, wsel_q, busy};
      A_DIV:   reg_rdata = 32'(div_q);
      A_PHY:   reg_rdata = {27'b0, phy_q};
      A_TXD:   reg_rdata = {16'b0, txd_q};
      A_RXD:   reg_rdata = {16'b0, rxd_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_engine_chk.sv
module mdio_mgmt_engine_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [IDX_W-1:0] idx,
  input logic [4:0]       regn_q,
  input logic             wsel_q
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc && idx == '0);
  p_preamble_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && idx < IDX_W'(32) |-> mdio_oe && mdio_o);
  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mdc) && $past(idx) == '1);
  p_fields_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(regn_q) && $stable(wsel_q));
endmodule

bind mdio_mgmt_engine mdio_mgmt_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .idx(idx), .regn_q(regn_q), .wsel_q(wsel_q)
);

// File: tb/mdio_mgmt_engine_tb.sv
module mdio_mgmt_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // behavioural reference
  bit          busy_m = 0;
  bit          wsel_m = 0;
  int          e = 0;
  int          h = 11;
  int          div_m = 10;
  logic [4:0]  regn_m = 0, phy_m = 0;
  logic [15:0] tx_m = 0, rx_m = 0;
  logic [15:0] resp = 16'h0000;
  logic [63:0] frame_m = '1;
  logic [63:0] cap = '0;

  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      busy_m = 0; wsel_m = 0; e = 0; div_m = 10; regn_m = 0;
      phy_m = 0; tx_m = 0; rx_m = 0;
    end else begin
      was_busy = busy_m;
      if (busy_m) begin
        e++;
        if (e == 128 * h) begin
          busy_m = 0;
          if (!wsel_m) rx_m = resp;
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (!was_busy) begin
            regn_m = reg_wdata[7:3];
            wsel_m = reg_wdata[1];
            if (reg_wdata[0]) begin
              busy_m = 1; e = 0; h = div_m + 1;
              frame_m = {32'hFFFF_FFFF, 2'b01, wsel_m ? 2'b01 : 2'b10,
                         phy_m, regn_m, 2'b10, tx_m};
            end
          end
          3'd1: div_m = int'(reg_wdata[7:0]);
          3'd2: phy_m = reg_wdata[4:0];
          3'd3: tx_m = reg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // behavioural PHY: answers reads, pull-up otherwise
  always_comb begin
    int b;
    b = e / (2 * h);
    if (busy_m && !wsel_m && b >= 47)
      mdio_i = (b == 47) ? 1'b0 : resp[63 - b];
    else
      mdio_i = 1'b1;
  end

  always @(posedge mdc) cap <= {cap[62:0], mdio_oe ? mdio_o : mdio_i};

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int b;
      bit exp_mdc, exp_oe;
      b = e / (2 * h);
      exp_mdc = busy_m && ((e / h) % 2 == 1);
      exp_oe  = busy_m && (wsel_m || b < 46);
      check("R3 mdc", 64'(mdc), 64'(exp_mdc));
      check("R5 mdio_oe", 64'(mdio_oe), 64'(exp_oe));
      if (exp_oe) check("R4 mdio_o", 64'(mdio_o), 64'(frame_m[63 - b]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_done(string tag, input int expect_cycles);
    int n;
    n = 0;
    @(negedge clk);
    reg_addr = 3'd0;
    while (reg_rdata[0] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(tag, 64'(n <= expect_cycles), 64'(1));
  endtask

  task automatic ctl_start(input logic [4:0] rn, input bit w);
    cap = '0;
    wr(3'd0, {24'b0, rn, 1'b0, w, 1'b1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mdc at reset", 64'(mdc), 64'(0));
    check("R1 oe at reset", 64'(mdio_oe), 64'(0));
    rd("R1 divider reset", 3'd1, 32'd10);
    rd("R1 control reset", 3'd0, 32'd0);
    rd("R1 rx reset", 3'd4, 32'd0);

    // write frame at default divider
    wr(3'd2, 32'h0000_0013);
    wr(3'd3, 32'hDEAD_A5C3);
    rd("R2 phy readback", 3'd2, 32'h13);
    rd("R2 tx readback", 3'd3, 32'hA5C3);
    ctl_start(5'h1E, 1'b1);
    rd("R2 start reads busy", 3'd0, {24'b0, 5'h1E, 3'b011});
    wr(3'd0, {24'b0, 5'h05, 3'b001});
    rd("R8 control write ignored", 3'd0, {24'b0, 5'h1E, 3'b011});
    wr(3'd3, 32'h0000_1111);
    wait_done("R7 write completes", 128 * 11);
    check("R4 write frame at PHY", cap,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h1E, 2'b10, 16'hA5C3});
    rd("R2 start cleared", 3'd0, {24'b0, 5'h1E, 3'b010});

    // read at divider 0
    wr(3'd1, 32'd0);
    resp = 16'h8E71;
    ctl_start(5'h02, 1'b0);
    wr(3'd1, 32'd7);
    wait_done("R7 read completes div0", 128);
    check("R5 read frame at PHY", cap,
          {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h13, 5'h02, 2'b10, 16'h8E71});
    rd("R6 rx data div0", 3'd4, 32'h0000_8E71);
    rd("R9 divider updated", 3'd1, 32'd7);

    // read at divider 2, all-ones address fields
    wr(3'd1, 32'd2);
    wr(3'd2, 32'h0000_001F);
    resp = 16'h8001;
    ctl_start(5'h1F, 1'b0);
    wait_done("R7 read completes div2", 128 * 3);
    rd("R6 rx data div2", 3'd4, 32'h0000_8001);

    // write at divider 2, then rx must hold
    wr(3'd3, 32'h0000_FFFF);
    ctl_start(5'h00, 1'b1);
    wait_done("R7 write completes div2", 128 * 3);
    check("R4 write frame div2", cap,
          {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'hFFFF});
    rd("R6 rx unchanged by write", 3'd4, 32'h0000_8001);
    repeat (4) @(negedge clk);
    check("R3 mdc idles low", 64'(mdc), 64'(0));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule